// File: doc/BRIEF.md
# Test-and-test-and-set spin lock engine

This block acquires and releases a one-word spin lock held in shared memory. It acts for a client, such as a processor core or an accelerator, and reaches the memory through one request port that offers three operations: plain read, plain write and atomic swap. The lock word is 0 when the lock is free and 1 when it is held.

To acquire the lock, the engine spins on plain reads for as long as the word reads nonzero. Once a read returns 0, it issues a single atomic swap that writes 1. If the swap returns 0, the lock belongs to the client. If the swap returns nonzero, another requester took the lock in the meantime, and the engine goes back to spinning on reads. It never retries the swap straight away. To release the lock, the engine issues one plain write of 0.

The engine keeps only one memory transaction in flight at a time. Three saturating counters let an observer compare how many reads were issued with how many swaps were attempted.

Top module: `ttas_lock_engine`

## Requirements
- R1: After reset the engine is idle, `mem_req_valid`, `acq_done`, `rel_done` and `rel_err` are low, and all three counters read 0.
- R2: An acquire starts with a plain read (opcode 00). The lock address is sampled in the cycle `acquire_req` is accepted while idle. Every request of that acquisition and of the following release carries that address, even if `lock_addr` changes later.
- R3: While a read returns a nonzero word, the engine issues another plain read and no swap.
- R4: A read that returns 0 is followed by exactly one swap request (opcode 10) with write data 1.
- R5: A swap that returns nonzero counts as a failure, and the engine resumes plain reads before it tries any further swap.
- R6: A swap that returns 0 makes `acq_done` pulse high for one cycle, and the lock is then held. An uncontended acquisition uses exactly one read and one swap.
- R7: A release request while the lock is held produces one write (opcode 01) of data 0. `rel_done` pulses for one cycle after that write's response, and the engine then returns to idle.
- R8: A release request while the lock is not held makes `rel_err` pulse for one cycle and issues no memory request. An acquire request while the engine is not idle is ignored.
- R9: A request stays valid, with opcode, address and write data unchanged, until `mem_req_ready` accepts it. No new request is issued while a response is still outstanding.
- R10: Each counter stops at 2^CNT_W-1 and does not wrap.
- R11: `rd_count` counts accepted reads, `swap_count` counts accepted swaps, and `fail_count` counts swap responses that return nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_addr | input | ADDR_W | Address of the lock word, sampled when an acquire starts |
| acquire_req | input | 1 | Request to acquire the lock (acted on only when idle) |
| release_req | input | 1 | Request to release the lock |
| acq_done | output | 1 | One-cycle pulse: the lock has been acquired |
| rel_done | output | 1 | One-cycle pulse: the release write has completed |
| rel_err | output | 1 | One-cycle pulse: release requested while the lock is not held |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | 00 read, 01 write, 10 swap |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write or swap data |
| mem_rsp_valid | input | 1 | Response valid (one for each accepted request) |
| mem_rsp_rdata | input | DATA_W | Read data, or the previous word for a swap |
| rd_count | output | CNT_W | Saturating count of plain reads issued |
| swap_count | output | CNT_W | Saturating count of swaps issued |
| fail_count | output | CNT_W | Saturating count of swaps that lost the race |

## Verification
The bench builds the engine with ADDR_W=8, DATA_W=8 and CNT_W=4. With 4-bit counters, saturation at 15 happens within a single acquisition that spins through about twenty reads. The narrow address makes a change of `lock_addr` in the middle of an acquisition easy to spot. The bench's memory model can make a competing requester take the lock between a successful read and the swap, and it can free the lock after a chosen number of reads. It can also pull `mem_req_ready` low on a pseudo-random pattern, which covers request stability under backpressure.

// File: rtl/ttas_lock_pkg.sv
package ttas_lock_pkg;

  typedef enum logic [1:0] {
    MOP_READ  = 2'b00,
    MOP_WRITE = 2'b01,
    MOP_SWAP  = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_SW_REQ,
    ST_SW_WAIT,
    ST_HELD,
    ST_RL_REQ,
    ST_RL_WAIT
  } lock_state_e;

  localparam int NUM_CTRS = 3;
  localparam int CTR_READ = 0;
  localparam int CTR_SWAP = 1;
  localparam int CTR_FAIL = 2;

endpackage

// File: rtl/ttas_sat_ctr.sv
module ttas_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != CMAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ttas_lock_seq.sv
module ttas_lock_seq
  import ttas_lock_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              acquire_req,
  input  logic              release_req,
  output logic              acq_done,
  output logic              rel_done,
  output logic              rel_err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              ev_read,
  output logic              ev_swap,
  output logic              ev_fail
);
  localparam logic [DATA_W-1:0] FREE_VAL = '0;
  localparam logic [DATA_W-1:0] TAKEN_VAL = DATA_W'(1);

  lock_state_e       state_q, state_d;
  mem_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_free;

  assign rsp_free = (rsp_rdata == FREE_VAL);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (acquire_req) state_d = ST_RD_REQ;
      ST_RD_REQ:  if (req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rsp_valid) state_d = rsp_free ? ST_SW_REQ : ST_RD_REQ;
      ST_SW_REQ:  if (req_ready) state_d = ST_SW_WAIT;
      ST_SW_WAIT: if (rsp_valid) state_d = rsp_free ? ST_HELD : ST_RD_REQ;
      ST_HELD:    if (release_req) state_d = ST_RL_REQ;
      ST_RL_REQ:  if (req_ready) state_d = ST_RL_WAIT;
      ST_RL_WAIT: if (rsp_valid) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_valid <= 1'b0;
      op_q      <= MOP_READ;
      req_wdata <= FREE_VAL;
      addr_q    <= '0;
      acq_done  <= 1'b0;
      rel_done  <= 1'b0;
      rel_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_valid <= (state_d == ST_RD_REQ) || (state_d == ST_SW_REQ) ||
                   (state_d == ST_RL_REQ);
      case (state_d)
        ST_SW_REQ: begin
          op_q      <= MOP_SWAP;
          req_wdata <= TAKEN_VAL;
        end
        ST_RL_REQ: begin
          op_q      <= MOP_WRITE;
          req_wdata <= FREE_VAL;
        end
        default: begin
          op_q      <= MOP_READ;
          req_wdata <= FREE_VAL;
        end
      endcase
      if ((state_q == ST_IDLE) && acquire_req) addr_q <= cfg_addr;
      acq_done <= (state_q == ST_SW_WAIT) && rsp_valid && rsp_free;
      rel_done <= (state_q == ST_RL_WAIT) && rsp_valid;
      rel_err  <= release_req && (state_q != ST_HELD);
    end
  end

  assign req_op   = op_q;
  assign req_addr = addr_q;

  assign ev_read = (state_q == ST_RD_REQ) && req_ready;
  assign ev_swap = (state_q == ST_SW_REQ) && req_ready;
  assign ev_fail = (state_q == ST_SW_WAIT) && rsp_valid && !rsp_free;
endmodule

// File: rtl/ttas_lock_engine.sv
module ttas_lock_engine
  import ttas_lock_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              acquire_req,
  input  logic              release_req,
  output logic              acq_done,
  output logic              rel_done,
  output logic              rel_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_req_op,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  swap_count,
  output logic [CNT_W-1:0]  fail_count
);
  logic [NUM_CTRS-1:0] ctr_inc;
  logic [CNT_W-1:0]    ctr_val [NUM_CTRS];

  ttas_lock_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_addr   (lock_addr),
    .acquire_req(acquire_req),
    .release_req(release_req),
    .acq_done   (acq_done),
    .rel_done   (rel_done),
    .rel_err    (rel_err),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_op     (mem_req_op),
    .req_addr   (mem_req_addr),
    .req_wdata  (mem_req_wdata),
    .rsp_valid  (mem_rsp_valid),
    .rsp_rdata  (mem_rsp_rdata),
    .ev_read    (ctr_inc[CTR_READ]),
    .ev_swap    (ctr_inc[CTR_SWAP]),
    .ev_fail    (ctr_inc[CTR_FAIL])
  );

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    ttas_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .inc  (ctr_inc[i]),
      .count(ctr_val[i])
    );
  end

  assign rd_count   = ctr_val[CTR_READ];
  assign swap_count = ctr_val[CTR_SWAP];
  assign fail_count = ctr_val[CTR_FAIL];
endmodule

// File: rtl/ttas_lock_engine_chk.sv
module ttas_lock_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acq_done,
  input logic              rel_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [1:0]        mem_req_op,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_rdata,
  input logic [CNT_W-1:0]  rd_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic       pend;
  logic [1:0] pend_op;
  logic       read_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pend_op <= 2'b00;
      read_ok <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        pend    <= 1'b1;
        pend_op <= mem_req_op;
        if (mem_req_op == 2'b10) read_ok <= 1'b0;
      end else if (mem_rsp_valid) begin
        pend <= 1'b0;
        if (pend && (pend_op == 2'b00)) read_ok <= (mem_rsp_rdata == '0);
      end
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_op) &&
      $stable(mem_req_addr) && $stable(mem_req_wdata))); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !pend); // R9

  AST_SWAP_AFTER_FREE_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && (mem_req_op == 2'b10)) |-> read_ok); // R3

  AST_SWAP_DATA_ONE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && (mem_req_op == 2'b10)) |-> (mem_req_wdata == DATA_W'(1))); // R4

  AST_RELEASE_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && (mem_req_op == 2'b01)) |-> (mem_req_wdata == '0)); // R7

  AST_ACQ_ON_FREE_SWAP: assert property (@(posedge clk) disable iff (rst)
    acq_done |-> $past(mem_rsp_valid && pend && (pend_op == 2'b10) &&
      (mem_rsp_rdata == '0))); // R6

  AST_REL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    rel_done |-> $past(mem_rsp_valid && pend && (pend_op == 2'b01))); // R7

  AST_CTR_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (rd_count == CMAX) |=> (rd_count == CMAX)); // R10
endmodule

bind ttas_lock_engine ttas_lock_engine_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acq_done     (acq_done),
  .rel_done     (rel_done),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_op   (mem_req_op),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_rdata(mem_rsp_rdata),
  .rd_count     (rd_count)
);

// File: tb/test_ttas_lock_engine.sv
`timescale 1ns/1ps
module test_ttas_lock_engine;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] lock_addr = '0;
  logic          acquire_req = 1'b0, release_req = 1'b0;
  logic          acq_done, rel_done, rel_err;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [1:0]    mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [CW-1:0] rd_count, swap_count, fail_count;

  ttas_lock_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_ttas_lock_engine (
    .clk(clk), .rst(rst), .lock_addr(lock_addr),
    .acquire_req(acquire_req), .release_req(release_req),
    .acq_done(acq_done), .rel_done(rel_done), .rel_err(rel_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .rd_count(rd_count),
    .swap_count(swap_count), .fail_count(fail_count)
  );

  // Memory model: lock word, competing requester, bench transaction counts
  logic          cfg_load = 1'b0;
  logic [DW-1:0] cfg_word = '0;
  int            cfg_rel = 0;
  logic          cfg_steal = 1'b0;
  logic          stall_en = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  logic [DW-1:0] word;
  int            rel_after;
  logic          steal, need_read;
  int            n_rd, n_sw, n_wr, n_badaddr, n_viol, n_unstable;
  logic          prev_stall;
  logic [1:0]    prev_op;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wdata;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (cfg_load) begin
      word <= cfg_word; rel_after <= cfg_rel; steal <= cfg_steal;
      need_read <= 1'b1; n_rd <= 0; n_sw <= 0; n_wr <= 0;
      n_badaddr <= 0; n_viol <= 0; n_unstable <= 0; prev_stall <= 1'b0;
    end else begin
      if (prev_stall && !(mem_req_valid && mem_req_op == prev_op &&
          mem_req_addr == prev_addr && mem_req_wdata == prev_wdata))
        n_unstable <= n_unstable + 1;
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_op <= mem_req_op; prev_addr <= mem_req_addr; prev_wdata <= mem_req_wdata;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_addr != exp_addr) n_badaddr <= n_badaddr + 1;
        case (mem_req_op)
          2'b00: begin
            n_rd <= n_rd + 1;
            mem_rsp_rdata <= word;
            need_read <= (word != '0);
            if (word != '0 && rel_after > 0) begin
              rel_after <= rel_after - 1;
              if (rel_after == 1) word <= '0;
            end
          end
          2'b10: begin
            n_sw <= n_sw + 1;
            if (need_read) n_viol <= n_viol + 1;
            need_read <= 1'b1;
            if (steal) begin
              mem_rsp_rdata <= DW'(1); word <= DW'(1); steal <= 1'b0;
            end else begin
              mem_rsp_rdata <= word; word <= mem_req_wdata;
            end
          end
          default: begin
            n_wr <= n_wr + 1;
            word <= mem_req_wdata;
            mem_rsp_rdata <= '0;
          end
        endcase
      end
    end
  end

  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= !stall_en || lfsr[0];
  end

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [DW-1:0] w, input int rel, input logic stl,
                          input logic stall);
    @(negedge clk);
    rst = 1'b1; acquire_req = 1'b0; release_req = 1'b0;
    cfg_word = w; cfg_rel = rel; cfg_steal = stl; stall_en = stall;
    cfg_load = 1'b1;
    repeat (3) @(negedge clk);
    cfg_load = 1'b0; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_acquire(input logic [AW-1:0] a);
    lock_addr = a; acquire_req = 1'b1;
    @(negedge clk);
    acquire_req = 1'b0; lock_addr = ~a;
  endtask

  task automatic wait_acq(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (acq_done) seen = 1;
    end
  endtask

  task automatic wait_rel(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (rel_done) seen = 1;
    end
  endtask

  task automatic t_reset;
    do_reset('0, 0, 1'b0, 1'b0);
    chk("R1 req_valid after reset", int'(mem_req_valid), 0);
    chk("R1 pulses after reset", int'({acq_done, rel_done, rel_err}), 0);
    chk("R1 counters after reset", int'(rd_count) + int'(swap_count) + int'(fail_count), 0);
  endtask

  task automatic t_uncontended;
    bit seen;
    do_reset('0, 0, 1'b0, 1'b0);
    exp_addr = 8'h3C;
    pulse_acquire(8'h3C);
    wait_acq(seen);
    chk("R6 acq_done seen", int'(seen), 1);
    @(negedge clk);
    chk("R6 acq_done is one cycle", int'(acq_done), 0);
    chk("R6 single read", n_rd, 1);
    chk("R4 single swap", n_sw, 1);
    chk("R4 lock word set to 1", int'(word), 1);
    chk("R2 address sampled at start", n_badaddr, 0);
    chk("R11 rd_count", int'(rd_count), 1);
    chk("R11 swap_count", int'(swap_count), 1);
    chk("R11 fail_count", int'(fail_count), 0);
    pulse_acquire(8'h77);
    repeat (6) @(negedge clk);
    chk("R8 acquire while held ignored", n_rd + n_sw, 2);
    release_req = 1'b1;
    @(negedge clk);
    release_req = 1'b0;
    wait_rel(seen);
    chk("R7 rel_done seen", int'(seen), 1);
    chk("R7 one write", n_wr, 1);
    chk("R7 word freed", int'(word), 0);
    chk("R2 release address", n_badaddr, 0);
  endtask

  task automatic t_contended;
    bit seen;
    do_reset(DW'(1), 5, 1'b0, 1'b1);
    exp_addr = 8'h91;
    pulse_acquire(8'h91);
    wait_acq(seen);
    chk("R3 acquired after spinning", int'(seen), 1);
    chk("R3 reads while held", n_rd, 6);
    chk("R3 no swap while held", n_viol, 0);
    chk("R3 one swap", n_sw, 1);
    chk("R9 request stable under stall", n_unstable, 0);
    chk("R11 rd_count contended", int'(rd_count), 6);
  endtask

  task automatic t_race;
    bit seen;
    do_reset('0, 3, 1'b1, 1'b0);
    exp_addr = 8'h12;
    pulse_acquire(8'h12);
    wait_acq(seen);
    chk("R5 acquired after lost race", int'(seen), 1);
    chk("R5 reads", n_rd, 5);
    chk("R5 swaps", n_sw, 2);
    chk("R5 swap only after fresh free read", n_viol, 0);
    chk("R11 fail_count", int'(fail_count), 1);
    chk("R11 swap_count race", int'(swap_count), 2);
  endtask

  task automatic t_spurious;
    do_reset('0, 0, 1'b0, 1'b0);
    exp_addr = 8'h00;
    release_req = 1'b1;
    @(negedge clk);
    release_req = 1'b0;
    chk("R8 rel_err when idle", int'(rel_err), 1);
    @(negedge clk);
    chk("R8 rel_err one cycle", int'(rel_err), 0);
    chk("R8 no request when idle", int'(mem_req_valid) + n_wr + n_rd, 0);
    do_reset(DW'(1), 0, 1'b0, 1'b0);
    exp_addr = 8'h44;
    pulse_acquire(8'h44);
    repeat (10) @(negedge clk);
    release_req = 1'b1;
    @(negedge clk);
    release_req = 1'b0;
    chk("R8 rel_err while spinning", int'(rel_err), 1);
    repeat (6) @(negedge clk);
    chk("R8 no write while spinning", n_wr, 0);
    chk("R8 no rel_done while spinning", int'(rel_done), 0);
    chk("R3 still spinning without swap", n_sw, 0);
  endtask

  task automatic t_saturate;
    bit seen;
    do_reset(DW'(1), 20, 1'b0, 1'b0);
    exp_addr = 8'hE0;
    pulse_acquire(8'hE0);
    wait_acq(seen);
    chk("R10 acquired", int'(seen), 1);
    chk("R10 bench read total", n_rd, 21);
    chk("R10 rd_count saturated", int'(rd_count), CMAX);
    chk("R10 swap_count", int'(swap_count), 1);
  endtask

  initial begin
    t_reset;
    t_uncontended;
    t_contended;
    t_race;
    t_spurious;
    t_saturate;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule